// File: doc/BRIEF.md
# Frame Buffer Rectangle Transfer Engine

This block copies a rectangular region of 16-bit pixels between a 32-bit data port and a frame buffer held in a synchronous single-port RAM. The frame buffer is 2^XW pixels wide and 2^YW lines tall, with defaults of 1024 by 512. A transfer begins with a one-cycle start strobe. The strobe carries a position word, a size word and a direction flag. The engine then walks the rectangle row by row, one pixel per RAM access, and packs or unpacks two pixels per data word. The lower half of each word comes first.

The pixel stream runs continuously across row ends. A data word can therefore straddle two rows, and the walker keeps its column position between words however long the gap is. For reads, the engine fetches the first word as soon as the transfer starts and presents it before any request. While a read transfer still has rows left, an image-ready flag is high. A busy flag is high while rows remain, and a one-cycle done pulse marks the last pixel.

Top module: `fbx_rect_xfer`

## Requirements
- R1: Start column X is pos_i[XW-1:0] and start line Y is pos_i[16+YW-1:16]. All other position bits are ignored.
- R2: Width is ((size_i[XW-1:0]-1) mod 2^XW)+1 and height is ((size_i[16+YW-1:16]-1) mod 2^YW)+1, so a zero field selects the full frame dimension. All other size bits are ignored.
- R3: Pixels are moved in row-major order, the low 16 bits of a word before the high 16 bits. Pixel (col, row) of the rectangle uses RAM address line*2^XW + X + col.
- R4: The line index advances modulo 2^YW, so a rectangle running past the bottom line continues at line 0.
- R5: Columns do not wrap inside a row. X + col may carry into the line bits, and address bits above XW+YW are dropped.
- R6: Write words may arrive with any gap between them. The column and line position are kept, and a word may span the end of one row and the start of the next.
- R7: img_rdy_o is high from the cycle after a read start until the last row has been fetched from RAM, and low at all other times.
- R8: After a read start, rd_valid_o rises with the first two pixels and no rd_pop_i is needed. rd_data_o and rd_valid_o hold steady until popped.
- R9: busy_o is high while rows remain. done_o is a single-cycle pulse issued once per transfer, after the final pixel, when busy_o is already low.
- R10: With an odd pixel count, the high half of the last write word is discarded (no RAM write), and the high half of the last read word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle transfer start; restarts any transfer in progress |
| dir_rd_i | input | 1 | 1 = frame buffer to port, 0 = port to frame buffer |
| pos_i | input | 32 | Position word (X, Y fields) |
| size_i | input | 32 | Size word (width, height fields) |
| wr_valid_i | input | 1 | Write data word present |
| wr_data_i | input | 32 | Write data word, two pixels |
| wr_ready_o | output | 1 | Write word accepted this cycle when valid |
| rd_pop_i | input | 1 | Consume the presented read word |
| rd_valid_o | output | 1 | Read word presented |
| rd_data_o | output | 32 | Read data word, two pixels |
| busy_o | output | 1 | Rows remain in the current transfer |
| done_o | output | 1 | One-cycle completion pulse |
| img_rdy_o | output | 1 | Read transfer has rows left to fetch |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | XW+YW | RAM pixel address |
| mem_wdata_o | output | 16 | RAM write pixel |
| mem_rdata_i | input | 16 | RAM read pixel, one cycle after the access |

## Verification
The bench builds the engine with XW=4 and YW=3, a 16 by 8 pixel frame buffer of 128 locations, so the RAM model is a plain array. At this size a zero size word covers the whole frame in 64 words. A rectangle near the bottom wraps to line 0 within a few rows. A start column near the right edge carries into the next line, and at the last line it runs past the top address, which tests the dropped upper bits. Odd widths let words straddle rows and leave a half-filled final word in both directions.

// File: rtl/fbx_pkg.sv
// Shared types for the frame buffer rectangle transfer engine.
// Assumes: nothing beyond the standard language.
package fbx_pkg;

    // Sequencer states: write path takes two pixels per word, read path prefetches a word.
    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_LO,
        S_WR_HI,
        S_RD_LO,
        S_RD_HI,
        S_RD_FIN,
        S_RD_HOLD
    } fbx_state_e;

endpackage

// File: rtl/fbx_walker.sv
// Rectangle address walker. Decodes the start position and the size with the
// minus-one / mask / plus-one rule and steps one pixel at a time in row-major order.
// Assumes: XW <= 16 so the line field at bit 16 never overlaps the column field;
// load_i takes precedence over step_i; steps with no rows left are ignored.
module fbx_walker #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [31:0]         pos_i,
    input  logic [31:0]         size_i,
    input  logic                step_i,
    output logic [XW+YW-1:0]    addr_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int AW = XW + YW;

    logic [XW-1:0] x0_q, wm1_q, col_q;
    logic [YW-1:0] row_q;
    logic [YW:0]   rem_q;
    logic          done_q;
    logic [XW-1:0] wm1_d;
    logic [YW-1:0] hm1_d;

    // Decode width-1 and height-1 straight from the size fields.
    assign wm1_d = size_i[XW-1:0] - {{(XW-1){1'b0}}, 1'b1};
    assign hm1_d = size_i[16 +: YW] - {{(YW-1){1'b0}}, 1'b1};

    // Pixel address: line base plus start column plus column; carries beyond AW drop.
    assign addr_o = {row_q, {XW{1'b0}}} + {{YW{1'b0}}, x0_q} + {{YW{1'b0}}, col_q};
    assign busy_o = (rem_q != '0);
    assign done_o = done_q;

    // Walker state: load on start, otherwise advance column, then line, per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x0_q   <= '0;
            wm1_q  <= '0;
            col_q  <= '0;
            row_q  <= '0;
            rem_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i) begin
                x0_q  <= pos_i[XW-1:0];
                row_q <= pos_i[16 +: YW];
                wm1_q <= wm1_d;
                col_q <= '0;
                rem_q <= {1'b0, hm1_d} + {{YW{1'b0}}, 1'b1};
            end else if (step_i && busy_o) begin
                if (col_q == wm1_q) begin
                    col_q <= '0;
                    row_q <= row_q + 1'b1;
                    rem_q <= rem_q - 1'b1;
                    if (rem_q == {{YW{1'b0}}, 1'b1})
                        done_q <= 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end

    // R9: the count of rows left only shrinks unless a new rectangle is loaded.
    a_r9_rows_never_grow: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> rem_q <= $past(rem_q));

    // R9: completion is reported only once no rows are left.
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: rtl/fbx_rd_pack.sv
// Read word assembler: gathers two consecutive RAM pixels into one data word.
// Assumes: capture strobes arrive the cycle the RAM read data is valid.
module fbx_rd_pack #(
    parameter int PW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_lo_i,
    input  logic            cap_hi_i,
    input  logic            clr_hi_i,
    input  logic [PW-1:0]   rdata_i,
    output logic [2*PW-1:0] word_o
);
    // Word register: low half, then high half or zero when no pixel remains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
        end else begin
            if (cap_lo_i)
                word_o[PW-1:0] <= rdata_i;
            if (cap_hi_i)
                word_o[2*PW-1:PW] <= rdata_i;
            else if (clr_hi_i)
                word_o[2*PW-1:PW] <= '0;
        end
    end
endmodule

// File: rtl/fbx_rect_xfer.sv
// Frame buffer rectangle transfer engine top. Sequences RAM accesses for a
// rectangle in either direction, two pixels per 32-bit data word.
// Assumes: single-port RAM with one-cycle read latency; start_i may arrive at any
// time and restarts the engine.
module fbx_rect_xfer #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                dir_rd_i,
    input  logic [31:0]         pos_i,
    input  logic [31:0]         size_i,
    input  logic                wr_valid_i,
    input  logic [31:0]         wr_data_i,
    output logic                wr_ready_o,
    input  logic                rd_pop_i,
    output logic                rd_valid_o,
    output logic [31:0]         rd_data_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                img_rdy_o,
    output logic                mem_en_o,
    output logic                mem_we_o,
    output logic [XW+YW-1:0]    mem_addr_o,
    output logic [15:0]         mem_wdata_o,
    input  logic [15:0]         mem_rdata_i
);
    import fbx_pkg::*;

    localparam int PW = 16;

    fbx_state_e    state_q, state_d;
    logic          rd_mode_q;
    logic [PW-1:0] hi_q;
    logic          step, walk_busy;
    logic          cap_lo, cap_hi, clr_hi;

    fbx_walker #(.XW(XW), .YW(YW)) walker_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_i),
        .pos_i  (pos_i),
        .size_i (size_i),
        .step_i (step),
        .addr_o (mem_addr_o),
        .busy_o (walk_busy),
        .done_o (done_o)
    );

    fbx_rd_pack #(.PW(PW)) pack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_lo_i (cap_lo),
        .cap_hi_i (cap_hi),
        .clr_hi_i (clr_hi),
        .rdata_i  (mem_rdata_i),
        .word_o   (rd_data_o)
    );

    assign busy_o     = walk_busy;
    assign img_rdy_o  = rd_mode_q && walk_busy;
    assign rd_valid_o = (state_q == S_RD_HOLD);
    assign wr_ready_o = (state_q == S_WR_LO) && walk_busy && !start_i;

    // Sequencer: picks the RAM access, walker step and capture strobes for this cycle.
    always_comb begin
        state_d     = state_q;
        step        = 1'b0;
        mem_en_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = '0;
        cap_lo      = 1'b0;
        cap_hi      = 1'b0;
        clr_hi      = 1'b0;
        if (start_i) begin
            state_d = dir_rd_i ? S_RD_LO : S_WR_LO;
        end else begin
            case (state_q)
                S_WR_LO: begin
                    if (!walk_busy) begin
                        state_d = S_IDLE;
                    end else if (wr_valid_i) begin
                        mem_en_o    = 1'b1;
                        mem_we_o    = 1'b1;
                        mem_wdata_o = wr_data_i[PW-1:0];
                        step        = 1'b1;
                        state_d     = S_WR_HI;
                    end
                end
                S_WR_HI: begin
                    if (walk_busy) begin
                        mem_en_o    = 1'b1;
                        mem_we_o    = 1'b1;
                        mem_wdata_o = hi_q;
                        step        = 1'b1;
                    end
                    state_d = S_WR_LO;
                end
                S_RD_LO: begin
                    if (walk_busy) begin
                        mem_en_o = 1'b1;
                        step     = 1'b1;
                        state_d  = S_RD_HI;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
                S_RD_HI: begin
                    cap_lo = 1'b1;
                    if (walk_busy) begin
                        mem_en_o = 1'b1;
                        step     = 1'b1;
                        state_d  = S_RD_FIN;
                    end else begin
                        clr_hi  = 1'b1;
                        state_d = S_RD_HOLD;
                    end
                end
                S_RD_FIN: begin
                    cap_hi  = 1'b1;
                    state_d = S_RD_HOLD;
                end
                S_RD_HOLD: begin
                    if (rd_pop_i)
                        state_d = walk_busy ? S_RD_LO : S_IDLE;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // State, direction and the held upper pixel of an accepted write word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            rd_mode_q <= 1'b0;
            hi_q      <= '0;
        end else begin
            state_q <= state_d;
            if (start_i)
                rd_mode_q <= dir_rd_i;
            if (state_q == S_WR_LO && wr_valid_i && walk_busy && !start_i)
                hi_q <= wr_data_i[2*PW-1:PW];
        end
    end

    // R9: the completion pulse lasts one cycle.
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: a presented read word stays put until it is popped or a restart arrives.
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_pop_i && !start_i |=> rd_valid_o && $stable(rd_data_o));

    // R3: RAM is touched only while the rectangle still has pixels to move.
    a_r3_access_in_rect: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> walk_busy);

    // R10: no RAM write is issued while a read transfer is in progress.
    a_r10_no_write_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        img_rdy_o |-> !mem_we_o);

endmodule

// File: tb/fbx_rect_xfer_tb.sv
// Scoreboard bench: driver tasks queue expected RAM writes / read words,
// a monitor at the falling edge pops and compares them.
module fbx_rect_xfer_tb_top;
    localparam int XW = 4;
    localparam int YW = 3;
    localparam int FW = 1 << XW;
    localparam int FH = 1 << YW;
    localparam int AW = XW + YW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, dir_rd_i = 1'b0;
    logic [31:0] pos_i = '0, size_i = '0;
    logic wr_valid_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic wr_ready_o, rd_pop_i = 1'b0, rd_valid_o;
    logic [31:0] rd_data_o;
    logic busy_o, done_o, img_rdy_o, mem_en_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [15:0] mem_wdata_o, mem_rdata_i;

    int checks = 0, errors = 0, done_cnt = 0;
    string cur_tag = "R3";
    int wq_a[$], wq_d[$], rq[$];
    logic [15:0] ram [FW*FH];

    always #5 clk = ~clk;

    fbx_rect_xfer #(.XW(XW), .YW(YW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_rd_i(dir_rd_i),
        .pos_i(pos_i), .size_i(size_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
        .wr_ready_o(wr_ready_o), .rd_pop_i(rd_pop_i), .rd_valid_o(rd_valid_o),
        .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o), .img_rdy_o(img_rdy_o),
        .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    function automatic logic [15:0] pat(int a);
        return 16'(a * 37 + 5);
    endfunction

    function automatic int xaddr(int x, int y, int w, int p);
        return (((y + p / w) % FH) * FW + x + (p % w)) % (FW * FH);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // RAM model: one-cycle read latency, preloaded with a pattern.
    initial for (int i = 0; i < FW * FH; i++) ram[i] = pat(i);
    always @(posedge clk) begin
        if (mem_en_o) begin
            if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
            else mem_rdata_i <= ram[mem_addr_o];
        end
    end

    // Monitor: compare RAM writes and popped read words against the queues.
    always @(negedge clk) begin
        if (rst_n && done_o) done_cnt++;
        if (rst_n && mem_en_o && mem_we_o) begin
            if (wq_a.size() == 0) chk(0, cur_tag, "unexpected write", int'(mem_addr_o), -1);
            else begin
                chk(int'(mem_addr_o) == wq_a[0], cur_tag, "write addr", int'(mem_addr_o), wq_a[0]);
                chk(int'(mem_wdata_o) == wq_d[0], cur_tag, "write data", int'(mem_wdata_o), wq_d[0]);
                void'(wq_a.pop_front());
                void'(wq_d.pop_front());
            end
        end
        if (rst_n && rd_valid_o && rd_pop_i) begin
            if (rq.size() == 0) chk(0, cur_tag, "unexpected read word", int'(rd_data_o), -1);
            else begin
                chk(rd_data_o == 32'(rq[0]), cur_tag, "read word", int'(rd_data_o), rq[0]);
                void'(rq.pop_front());
            end
        end
    end

    task automatic kick(int x, int y, int sw, int sh, bit rd, int junk);
        @(posedge clk); #1;
        start_i = 1'b1; dir_rd_i = rd;
        pos_i  = (junk << 26) | (y << 16) | x | (junk << 10);
        size_i = (junk << 26) | (sh << 16) | sw | (junk << 10);
        done_cnt = 0;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic do_write(int x, int y, int sw, int sh, int gap, int seed, string tag);
        int w, h, np, nw;
        w = ((sw - 1) & (FW - 1)) + 1;
        h = ((sh - 1) & (FH - 1)) + 1;
        np = w * h;
        nw = (np + 1) / 2;
        cur_tag = tag;
        for (int p = 0; p < np; p++) begin
            wq_a.push_back(xaddr(x, y, w, p));
            wq_d.push_back((seed + p) & 16'hFFFF);
        end
        kick(x, y, sw, sh, 1'b0, 5);
        chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
        for (int k = 0; k < nw; k++) begin
            bit acc;
            wr_valid_i = 1'b1;
            wr_data_i = {16'(seed + 2 * k + 1), 16'(seed + 2 * k)};
            do begin
                @(negedge clk); acc = wr_ready_o;
                @(posedge clk); #1;
            end while (!acc);
            wr_valid_i = 1'b0;
            repeat (gap) @(posedge clk);
            #1;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(wq_a.size() == 0, tag, "pending writes", wq_a.size(), 0);
        chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        chk(busy_o == 1'b0, "R9", "busy after end", busy_o, 0);
        chk(wr_ready_o == 1'b0, "R10", "ready after end", wr_ready_o, 0);
        wq_a.delete(); wq_d.delete();
    endtask

    task automatic do_read(int x, int y, int sw, int sh, string tag);
        int w, h, np, nw;
        w = ((sw - 1) & (FW - 1)) + 1;
        h = ((sh - 1) & (FH - 1)) + 1;
        np = w * h;
        nw = (np + 1) / 2;
        cur_tag = tag;
        for (int k = 0; k < nw; k++) begin
            int lo, hi;
            lo = pat(xaddr(x, y, w, 2 * k));
            hi = (2 * k + 1 < np) ? int'(pat(xaddr(x, y, w, 2 * k + 1))) : 0;
            rq.push_back((hi << 16) | lo);
        end
        kick(x, y, sw, sh, 1'b1, 0);
        @(negedge clk);
        chk(img_rdy_o == 1'b1, "R7", "img_rdy after read start", img_rdy_o, 1);
        for (int k = 0; k < nw; k++) begin
            do @(negedge clk); while (!rd_valid_o);
            if (k == 0) begin
                repeat (3) @(negedge clk);
                chk(rd_valid_o == 1'b1, "R8", "preload held without pop", rd_valid_o, 1);
            end
            @(posedge clk); #1; rd_pop_i = 1'b1;
            @(negedge clk);
            @(posedge clk); #1; rd_pop_i = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rq.size() == 0, tag, "pending read words", rq.size(), 0);
        chk(img_rdy_o == 1'b0, "R7", "img_rdy after last row", img_rdy_o, 0);
        chk(rd_valid_o == 1'b0, "R8", "valid after final pop", rd_valid_o, 0);
        chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        rq.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R9", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0, "R9", "reset busy/done", {busy_o, done_o}, 0);
        chk(rd_valid_o == 0 && img_rdy_o == 0 && wr_ready_o == 0, "R7", "reset flags",
            {rd_valid_o, img_rdy_o, wr_ready_o}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        // Reads first, while the RAM still holds the pattern.
        do_read(2, 1, 3, 2, "R8");
        do_read(15, 7, 3, 1, "R10");
        do_read(4, 6, 2, 4, "R4");
        // Writes.
        do_write(3, 2, 2, 2, 0, 16'h1000, "R1");
        do_write(0, 0, 0, 0, 0, 16'h2000, "R2");
        do_write(0, 6, 2, 4, 0, 16'h3000, "R4");
        do_write(14, 7, 4, 1, 0, 16'h4000, "R5");
        do_write(5, 3, 3, 2, 4, 16'h5000, "R6");
        do_write(7, 1, 3, 1, 1, 16'h6000, "R10");
        do_write(1, 0, 5, 3, 2, 16'h7000, "R3");
        summary();
        $finish;
    end
endmodule